// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This block settles, for an 8-bit microcontroller core, whether a conditional relative branch goes and what it does to its operands on the way. The core presents one branch per request: a 4-bit kind code, the accumulator, the carry flag, the value of a tested bit, two compare operands, a decrement operand, the address of the following instruction and a signed 8-bit displacement. One clock later the unit returns the decision, the program counter to continue from, the updated carry, a request to clear the tested bit and the decremented byte with its write enable.

Supported conditions are accumulator zero or nonzero, carry set or clear, bit set or clear, bit set with clear-on-take, compare-and-branch-if-different, and decrement-and-branch-if-nonzero. Fetching operands and decoding instructions happen elsewhere in the core. All outputs are registered and keep their last value until the next request.

Top module: `brc_decide`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high; all other outputs change only in that cycle and otherwise keep their values.
- R2: When a branch is taken, `pc_out` equals `pc_next` plus `disp` read as a signed two's-complement byte (-128 to +127), modulo 2^16.
- R3: When a branch is not taken, `pc_out` equals `pc_next`.
- R4: Kind 0 is taken when `acc` is 0x00; kind 1 is taken when `acc` is not 0x00.
- R5: Kind 2 is taken when `cy_in` is 1; kind 3 is taken when `cy_in` is 0.
- R6: Kind 4 is taken when `bit_val` is 1; kind 5 is taken when `bit_val` is 0.
- R7: Kind 6 is taken when `bit_val` is 1, and `bit_clr` is 1 only for a taken kind 6.
- R8: Kind 7 is taken when `cmp_a` differs from `cmp_b`; `cy_out` becomes 1 when `cmp_a` is less than `cmp_b` as unsigned bytes and 0 otherwise, taken or not.
- R9: Kind 8 always raises `dec_we`, `dec_val` is `dec_src` minus one modulo 256 (0x00 gives 0xFF), and the branch is taken when `dec_val` is nonzero.
- R10: For every kind except 7, `cy_out` equals `cy_in`; `dec_we` is 0 for every kind except 8; `dec_val` always carries `dec_src` minus one.
- R11: Kinds 9 to 15 are never taken and raise neither `bit_clr` nor `dec_we`.
- R12: While `rst` is high at a clock edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A branch is presented this cycle |
| br_kind | input | 4 | Branch kind code (0 to 8 defined) |
| acc | input | 8 | Accumulator value |
| cy_in | input | 1 | Current carry flag |
| bit_val | input | 1 | Value of the tested bit |
| cmp_a | input | 8 | First compare operand |
| cmp_b | input | 8 | Second compare operand |
| dec_src | input | 8 | Operand to decrement |
| pc_next | input | 16 | Address of the following instruction |
| disp | input | 8 | Signed branch displacement |
| res_valid | output | 1 | Result presented this cycle |
| taken | output | 1 | Branch taken |
| pc_out | output | 16 | Program counter to continue from |
| cy_out | output | 1 | Updated carry flag |
| bit_clr | output | 1 | Request to clear the tested bit |
| dec_val | output | 8 | Decremented operand |
| dec_we | output | 1 | Write back `dec_val` |

## Verification
The bench aims at the wrap cases of decrement-and-branch: an operand of 0x00 must become 0xFF and branch, while 0x01 must become zero and fall through, so a design that tests the operand before decrementing inverts both. Compares of 0x7F against 0x80 expose a signed magnitude compare through the carry, and an equal compare must still clear the carry, which a design updating carry only on a taken branch would miss. Displacements of 0x7F, 0x80 and targets that cross 0x0000 and 0xFFFF catch a zero-extended or truncated offset, and a not-taken bit-test-and-clear catches a clear request raised on the kind alone.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [3:0] {
    BK_ACC_ZERO    = 4'd0,
    BK_ACC_NZ      = 4'd1,
    BK_CY_SET      = 4'd2,
    BK_CY_CLR      = 4'd3,
    BK_BIT_SET     = 4'd4,
    BK_BIT_CLR     = 4'd5,
    BK_BIT_SET_CLR = 4'd6,
    BK_CMP_NE      = 4'd7,
    BK_DEC_NZ      = 4'd8
  } br_kind_e;

  localparam int KIND_W = 4;

endpackage

// File: rtl/brc_cond.sv
module brc_cond
  import brc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [KIND_W-1:0] kind_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              cy_i,
  input  logic              bit_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              take_o,
  output logic              cy_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] dec_o,
  output logic              dec_wr_o
);

  localparam logic [DATA_W-1:0] ZERO = '0;
  localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};

  logic acc_is_zero;
  logic ops_differ;
  logic a_below_b;
  logic dec_nonzero;

  assign acc_is_zero = (acc_i == ZERO);
  assign ops_differ  = (a_i != b_i);
  assign a_below_b   = (a_i < b_i);
  assign dec_o       = src_i - ONE;
  assign dec_nonzero = (dec_o != ZERO);

  always_comb begin
    take_o   = 1'b0;
    cy_o     = cy_i;
    clr_o    = 1'b0;
    dec_wr_o = 1'b0;
    case (kind_i)
      BK_ACC_ZERO:    take_o = acc_is_zero;
      BK_ACC_NZ:      take_o = !acc_is_zero;
      BK_CY_SET:      take_o = cy_i;
      BK_CY_CLR:      take_o = !cy_i;
      BK_BIT_SET:     take_o = bit_i;
      BK_BIT_CLR:     take_o = !bit_i;
      BK_BIT_SET_CLR: begin
        take_o = bit_i;
        clr_o  = bit_i;
      end
      BK_CMP_NE: begin
        take_o = ops_differ;
        cy_o   = a_below_b;
      end
      BK_DEC_NZ: begin
        take_o   = dec_nonzero;
        dec_wr_o = 1'b1;
      end
      default: take_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] tgt_o
);

  logic [ADDR_W-1:0] disp_ext;

  generate
    if (DISP_W < ADDR_W) begin : g_extend
      assign disp_ext = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[ADDR_W-1:0];
    end
  endgenerate

  assign tgt_o = pc_i + disp_ext;

endmodule

// File: rtl/brc_decide.sv
module brc_decide
  import brc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        br_kind,
  input  logic [DATA_W-1:0] acc,
  input  logic              cy_in,
  input  logic              bit_val,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic [DATA_W-1:0] dec_src,
  input  logic [ADDR_W-1:0] pc_next,
  input  logic [DISP_W-1:0] disp,
  output logic              res_valid,
  output logic              taken,
  output logic [ADDR_W-1:0] pc_out,
  output logic              cy_out,
  output logic              bit_clr,
  output logic [DATA_W-1:0] dec_val,
  output logic              dec_we
);

  logic              c_take;
  logic              c_cy;
  logic              c_clr;
  logic [DATA_W-1:0] c_dec;
  logic              c_dec_wr;
  logic [ADDR_W-1:0] c_tgt;

  brc_cond #(.DATA_W(DATA_W)) u_cond (
    .kind_i   (br_kind),
    .acc_i    (acc),
    .cy_i     (cy_in),
    .bit_i    (bit_val),
    .a_i      (cmp_a),
    .b_i      (cmp_b),
    .src_i    (dec_src),
    .take_o   (c_take),
    .cy_o     (c_cy),
    .clr_o    (c_clr),
    .dec_o    (c_dec),
    .dec_wr_o (c_dec_wr)
  );

  brc_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_target (
    .pc_i   (pc_next),
    .disp_i (disp),
    .tgt_o  (c_tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      taken     <= 1'b0;
      pc_out    <= '0;
      cy_out    <= 1'b0;
      bit_clr   <= 1'b0;
      dec_val   <= '0;
      dec_we    <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        taken   <= c_take;
        pc_out  <= c_take ? c_tgt : pc_next;
        cy_out  <= c_cy;
        bit_clr <= c_clr;
        dec_val <= c_dec;
        dec_we  <= c_dec_wr;
      end
    end
  end

  // R1: a result follows every request by one cycle
  assert_res_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);

  // R1: outputs hold when no request was presented
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(pc_out) && $stable(taken) && $stable(cy_out) && $stable(dec_val)));

  // R3: fall-through address on a not-taken branch
  assert_fallthrough_R3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !taken) |-> (pc_out == $past(pc_next)));

  // R7: clear request only accompanies a taken branch
  assert_clr_needs_take_R7: assert property (@(posedge clk) disable iff (rst)
    bit_clr |-> taken);

  // R8: compare carry from unsigned magnitude
  assert_cmp_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && ($past(br_kind) == BK_CMP_NE)) |-> (cy_out == ($past(cmp_a) < $past(cmp_b))));

  // R10: write-back only for decrement-and-branch
  assert_we_kind_R10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && dec_we) |-> ($past(br_kind) == BK_DEC_NZ));

  // R11: undefined kinds have no effect
  assert_undef_inert_R11: assert property (@(posedge clk) disable iff (rst)
    (res_valid && ($past(br_kind) > 4'd8)) |-> (!taken && !bit_clr && !dec_we));

endmodule

// File: tb/brc_decide_tb.sv
module brc_decide_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [3:0]  kind;
    logic [7:0]  acc;
    logic        cy;
    logic        bt;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  src;
    logic [15:0] pc;
    logic [7:0]  disp;
    logic        e_tk;
    logic [15:0] e_pc;
    logic        e_cy;
    logic        e_clr;
    logic        e_we;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [0:NV-1] = '{
    // R4 accumulator zero / nonzero
    '{4'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h05, 16'h1000, 8'h10, 1'b1, 16'h1010, 1'b0, 1'b0, 1'b0},
    '{4'd0, 8'h01, 1'b1, 1'b0, 8'h00, 8'h00, 8'h05, 16'h1000, 8'h10, 1'b0, 16'h1000, 1'b1, 1'b0, 1'b0},
    '{4'd1, 8'h80, 1'b0, 1'b0, 8'h00, 8'h00, 8'h05, 16'h1000, 8'hF0, 1'b1, 16'h0FF0, 1'b0, 1'b0, 1'b0},
    '{4'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h05, 16'h1000, 8'hF0, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0},
    // R5 carry
    '{4'd2, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h05, 16'h1000, 8'h7F, 1'b1, 16'h107F, 1'b1, 1'b0, 1'b0},
    '{4'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h05, 16'h1000, 8'h7F, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0},
    '{4'd3, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h05, 16'h1000, 8'h80, 1'b1, 16'h0F80, 1'b0, 1'b0, 1'b0},
    '{4'd3, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h05, 16'h1000, 8'h80, 1'b0, 16'h1000, 1'b1, 1'b0, 1'b0},
    // R6 bit
    '{4'd4, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, 8'h05, 16'h1000, 8'h01, 1'b1, 16'h1001, 1'b0, 1'b0, 1'b0},
    '{4'd4, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h05, 16'h1000, 8'h01, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0},
    '{4'd5, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h05, 16'h1000, 8'h02, 1'b1, 16'h1002, 1'b0, 1'b0, 1'b0},
    '{4'd5, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, 8'h05, 16'h1000, 8'h02, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0},
    // R7 bit set with clear
    '{4'd6, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 8'h05, 16'h1000, 8'h04, 1'b1, 16'h1004, 1'b1, 1'b1, 1'b0},
    '{4'd6, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h05, 16'h1000, 8'h04, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0},
    // R8 compare
    '{4'd7, 8'h00, 1'b0, 1'b0, 8'h10, 8'h20, 8'h05, 16'h1000, 8'h08, 1'b1, 16'h1008, 1'b1, 1'b0, 1'b0},
    '{4'd7, 8'h00, 1'b1, 1'b0, 8'h20, 8'h10, 8'h05, 16'h1000, 8'h08, 1'b1, 16'h1008, 1'b0, 1'b0, 1'b0},
    '{4'd7, 8'h00, 1'b1, 1'b0, 8'h33, 8'h33, 8'h05, 16'h1000, 8'h08, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0},
    '{4'd7, 8'h00, 1'b0, 1'b0, 8'h7F, 8'h80, 8'h05, 16'h1000, 8'h08, 1'b1, 16'h1008, 1'b1, 1'b0, 1'b0},
    // R9 decrement and branch
    '{4'd8, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h05, 16'h1000, 8'hFC, 1'b1, 16'h0FFC, 1'b1, 1'b0, 1'b1},
    '{4'd8, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h1000, 8'hFC, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b1},
    '{4'd8, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h1000, 8'hFC, 1'b1, 16'h0FFC, 1'b0, 1'b0, 1'b1},
    // R11 undefined kinds
    '{4'd9, 8'h00, 1'b1, 1'b1, 8'h01, 8'h02, 8'h05, 16'h1000, 8'h10, 1'b0, 16'h1000, 1'b1, 1'b0, 1'b0},
    '{4'hF, 8'h00, 1'b1, 1'b1, 8'h01, 8'h02, 8'h00, 16'h1000, 8'h10, 1'b0, 16'h1000, 1'b1, 1'b0, 1'b0},
    // R2 target wraps over the address space
    '{4'd2, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h05, 16'hFFF0, 8'h20, 1'b1, 16'h0010, 1'b1, 1'b0, 1'b0},
    '{4'd2, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h05, 16'h0005, 8'hF0, 1'b1, 16'hFFF5, 1'b1, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [3:0]  br_kind;
  logic [7:0]  acc;
  logic        cy_in;
  logic        bit_val;
  logic [7:0]  cmp_a;
  logic [7:0]  cmp_b;
  logic [7:0]  dec_src;
  logic [15:0] pc_next;
  logic [7:0]  disp;
  logic        res_valid;
  logic        taken;
  logic [15:0] pc_out;
  logic        cy_out;
  logic        bit_clr;
  logic [7:0]  dec_val;
  logic        dec_we;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brc_decide u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .br_kind(br_kind),
    .acc(acc), .cy_in(cy_in), .bit_val(bit_val), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .dec_src(dec_src), .pc_next(pc_next), .disp(disp),
    .res_valid(res_valid), .taken(taken), .pc_out(pc_out), .cy_out(cy_out),
    .bit_clr(bit_clr), .dec_val(dec_val), .dec_we(dec_we)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    req_valid = vld;
    br_kind   = v.kind;
    acc       = v.acc;
    cy_in     = v.cy;
    bit_val   = v.bt;
    cmp_a     = v.a;
    cmp_b     = v.b;
    dec_src   = v.src;
    pc_next   = v.pc;
    disp      = v.disp;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t idle;
    idle = '0;
    rst = 1'b1;
    drive(idle, 1'b0);
    repeat (3) @(negedge clk);

    // R12: reset state
    chk("R12 res_valid", res_valid, 0);
    chk("R12 taken", taken, 0);
    chk("R12 pc_out", pc_out, 0);
    chk("R12 cy_out", cy_out, 0);
    chk("R12 bit_clr", bit_clr, 0);
    chk("R12 dec_val", dec_val, 0);
    chk("R12 dec_we", dec_we, 0);
    rst = 1'b0;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i], 1'b1);
      @(negedge clk);
      drive(idle, 1'b0);
      chk($sformatf("R1 res_valid v%0d", i), res_valid, 1);
      chk($sformatf("R2/R3/R4-R9/R11 taken v%0d", i), taken, TBL[i].e_tk);
      chk($sformatf("R2/R3 pc_out v%0d", i), pc_out, TBL[i].e_pc);
      chk($sformatf("R8/R10 cy_out v%0d", i), cy_out, TBL[i].e_cy);
      chk($sformatf("R7 bit_clr v%0d", i), bit_clr, TBL[i].e_clr);
      chk($sformatf("R9/R10 dec_we v%0d", i), dec_we, TBL[i].e_we);
      chk($sformatf("R9/R10 dec_val v%0d", i), dec_val, 32'(8'(TBL[i].src - 8'h01)));
    end

    // R1: outputs hold while no request is presented
    drive(TBL[12], 1'b1);
    @(negedge clk);
    drive(TBL[20], 1'b0);
    @(negedge clk);
    chk("R1 idle res_valid", res_valid, 0);
    chk("R1 idle taken held", taken, 1);
    chk("R1 idle pc_out held", pc_out, 16'h1004);
    chk("R1 idle bit_clr held", bit_clr, 1);
    chk("R1 idle dec_we held", dec_we, 0);
    chk("R1 idle dec_val held", dec_val, 8'h04);

    // R1: back-to-back requests give consecutive results
    drive(TBL[19], 1'b1);
    @(negedge clk);
    chk("R9 b2b first dec_val", dec_val, 8'h00);
    chk("R9 b2b first taken", taken, 0);
    drive(TBL[20], 1'b1);
    @(negedge clk);
    drive(idle, 1'b0);
    chk("R1 b2b second res_valid", res_valid, 1);
    chk("R9 b2b second dec_val", dec_val, 8'hFF);
    chk("R9 b2b second taken", taken, 1);

    // R12: reset after activity clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R12 re-reset pc_out", pc_out, 0);
    chk("R12 re-reset dec_val", dec_val, 0);
    chk("R12 re-reset dec_we", dec_we, 0);
    chk("R12 re-reset taken", taken, 0);
    rst = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule